// File: doc/BRIEF.md
# Write-Back Data Cache Miss Controller

This block controls a direct-mapped data cache that keeps written data locally and allocates on writes. It accepts one load or store at a time from a processor port and checks the tag of the addressed frame. A load hit returns the word in the cycle after acceptance. A store hit marks the frame as modified and records the word in a one-entry pending-store register. That register updates the data array one cycle later, and a load that follows directly is served from it by an address comparison.

On a miss the controller asks the next level for the whole block. If the frame being replaced holds modified data, that data moves into a one-entry eviction buffer while the fill is outstanding. The buffer is written out only after the new block is installed, and only when the processor port has nothing to offer. The fill path therefore never waits for a writeback it does not depend on. A miss on the block that is still held in the buffer takes the block back from the buffer without any next-level read. A miss whose victim is modified while the buffer is still occupied waits until the buffer has been written out.

Top module: `wbCacheCtl`

## Requirements
- R1: While reset is held and in the first cycle after it, no next-level request and no processor response are raised, and the processor port is ready.
- R2: A load that hits returns the addressed word in the cycle after it is accepted, with no next-level traffic. In a response cycle the port is ready for the next request.
- R3: A store that hits causes no next-level write, neither at once nor while the port is idle afterwards, and a later load returns the stored word.
- R4: A load accepted in the cycle right after a store to the same word address returns the store data.
- R5: A miss that replaces a clean or empty frame causes exactly one block read and no block write. While a block read is outstanding the processor port is stalled.
- R6: Replacing a modified frame causes exactly one block write, which carries every word of the victim including earlier stores.
- R7: On a modified miss the block read is completed before the victim write starts. The write does not start before the missed access has been answered, and it starts only in a cycle without a processor response.
- R8: A store miss reads the block first and merges the store word into it. The other words of the block keep their next-level values.
- R9: A miss on the block held in the eviction buffer is served from the buffer with no next-level read. The block stays modified and is written back when it is later replaced.
- R10: A miss whose victim is modified while the buffer is occupied drains the buffer first. The next-level order is then: write of the old buffer block, read of the new block, write of the new victim.
- R11: A next-level request holds its address and direction stable until the next level signals completion.
- R12: Address fields, in words: bits [1:0] select the word within a four-word block, bits [4:2] select one of eight frames, and the upper bits are the tag. The next-level address is the word address without its two low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | Processor request present |
| cpuWrite | input | 1 | 1 for a store, 0 for a load |
| cpuAddr | input | ADDR_W | Word address |
| cpuWdata | input | DATA_W | Store data |
| cpuReady | output | 1 | Request accepted at this clock edge when valid |
| cpuRespValid | output | 1 | Access complete this cycle |
| cpuRdata | output | DATA_W | Load data, valid with the response |
| memReq | output | 1 | Next-level request, held until done |
| memWrite | output | 1 | 1 for a block write, 0 for a block read |
| memAddr | output | ADDR_W-2 | Block address |
| memWdata | output | DATA_W*WORDS | Block write data, word 0 in the low bits |
| memDone | input | 1 | Next-level transfer complete this cycle |
| memRdata | input | DATA_W*WORDS | Block read data, valid with memDone |

## Verification
The case hardest to reach from the ports is a miss that meets the eviction buffer still full. The buffer drains as soon as the processor port goes idle for a single cycle. The stimulus therefore issues every request in the same cycle as the previous response, with no idle cycle between them. It evicts a modified block, rewrites the incoming block, and then at once misses on a third block that maps to the same frame. The same gap-free chaining reaches the buffer-forwarding path, and an ordered log of next-level transfers checks the sequence.

// File: rtl/wbcPkg.sv
package wbcPkg;
  typedef enum logic [1:0] {sIdle, sLookup, sWaitBuf, sFill} ctlState_t;

  typedef struct packed {
    logic reqLoad;     // capture the processor request
    logic setPend;     // store hit: mark dirty, park word in pending store
    logic vicCopy;     // move dirty victim into eviction buffer
    logic installMem;  // install block returned by next level
    logic installWb;   // install block taken back from eviction buffer
    logic drainDone;   // eviction buffer written out
  } dpStrobe_t;
endpackage

// File: rtl/wbcDatapath.sv
module wbcDatapath import wbcPkg::*; #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int SETS   = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpStrobe_t                 stb,
  input  logic                      cpuWrite,
  input  logic [ADDR_W-1:0]         cpuAddr,
  input  logic [DATA_W-1:0]         cpuWdata,
  input  logic                      memWrite,
  input  logic [DATA_W*WORDS-1:0]   memRdata,
  output logic                      hit,
  output logic                      victimDirty,
  output logic                      wbFull,
  output logic                      wbHit,
  output logic                      reqWrite,
  output logic [DATA_W-1:0]         rdData,
  output logic [ADDR_W-$clog2(WORDS)-1:0] memAddr,
  output logic [DATA_W*WORDS-1:0]   memWdata
);
  localparam int OFF_W  = $clog2(WORDS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int BLK_W  = ADDR_W - OFF_W;
  localparam int LINE_W = DATA_W * WORDS;

  logic [TAG_W-1:0]  tagArr  [SETS];
  logic [LINE_W-1:0] dataArr [SETS];
  logic [SETS-1:0]   validArr, dirtyArr;

  logic [ADDR_W-1:0] reqAddr;
  logic [DATA_W-1:0] reqWdata;
  logic              pendValid;
  logic [ADDR_W-1:0] pendAddr;
  logic [DATA_W-1:0] pendData;
  logic [BLK_W-1:0]  wbBlk;
  logic [LINE_W-1:0] wbData;

  logic [OFF_W-1:0]  reqOff, pendOff;
  logic [IDX_W-1:0]  reqIdx, pendIdx;
  logic [TAG_W-1:0]  reqTag;
  logic [BLK_W-1:0]  reqBlk;

  assign reqOff  = reqAddr[OFF_W-1:0];
  assign reqIdx  = reqAddr[OFF_W +: IDX_W];
  assign reqTag  = reqAddr[ADDR_W-1 -: TAG_W];
  assign reqBlk  = reqAddr[ADDR_W-1:OFF_W];
  assign pendOff = pendAddr[OFF_W-1:0];
  assign pendIdx = pendAddr[OFF_W +: IDX_W];

  assign hit         = validArr[reqIdx] && (tagArr[reqIdx] == reqTag);
  assign victimDirty = validArr[reqIdx] && dirtyArr[reqIdx];
  assign wbHit       = wbFull && (wbBlk == reqBlk);
  assign rdData      = (pendValid && pendAddr == reqAddr) ? pendData
                       : dataArr[reqIdx][reqOff*DATA_W +: DATA_W];
  assign memAddr     = memWrite ? wbBlk : reqBlk;
  assign memWdata    = wbData;

  // request, pending store and eviction buffer control state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddr   <= '0;
      reqWrite  <= 1'b0;
      reqWdata  <= '0;
      pendValid <= 1'b0;
      pendAddr  <= '0;
      pendData  <= '0;
      wbFull    <= 1'b0;
      wbBlk     <= '0;
      validArr  <= '0;
      dirtyArr  <= '0;
    end else begin
      if (stb.reqLoad) begin
        reqAddr  <= cpuAddr;
        reqWrite <= cpuWrite;
        reqWdata <= cpuWdata;
      end
      pendValid <= stb.setPend;
      if (stb.setPend) begin
        pendAddr         <= reqAddr;
        pendData         <= reqWdata;
        dirtyArr[reqIdx] <= 1'b1;
      end
      if (stb.vicCopy) begin
        wbFull <= 1'b1;
        wbBlk  <= {tagArr[reqIdx], reqIdx};
      end else if (stb.installWb || stb.drainDone) begin
        wbFull <= 1'b0;
      end
      if (stb.installMem || stb.installWb) begin
        validArr[reqIdx] <= 1'b1;
        dirtyArr[reqIdx] <= stb.installWb;
      end
    end
  end

  // storage without reset: tags, block data, buffer data
  always_ff @(posedge clk) begin
    if (pendValid)
      dataArr[pendIdx][pendOff*DATA_W +: DATA_W] <= pendData;
    if (stb.vicCopy)
      wbData <= dataArr[reqIdx];
    if (stb.installMem) begin
      dataArr[reqIdx] <= memRdata;
      tagArr[reqIdx]  <= reqTag;
    end else if (stb.installWb) begin
      dataArr[reqIdx] <= wbData;
      tagArr[reqIdx]  <= reqTag;
    end
  end
endmodule

// File: rtl/wbcControl.sv
module wbcControl import wbcPkg::*; (
  input  logic      clk,
  input  logic      rstN,
  input  logic      cpuValid,
  input  logic      hit,
  input  logic      victimDirty,
  input  logic      wbFull,
  input  logic      wbHit,
  input  logic      reqWrite,
  input  logic      memDone,
  output dpStrobe_t stb,
  output logic      cpuReady,
  output logic      cpuRespValid,
  output logic      memReq,
  output logic      memWrite
);
  ctlState_t state, nxtState;
  logic vicDone, wbBusy, fillReq, drainGo;

  always_comb begin
    stb          = '0;
    nxtState     = state;
    cpuReady     = 1'b0;
    cpuRespValid = 1'b0;
    fillReq      = 1'b0;
    unique case (state)
      sIdle: begin
        cpuReady = 1'b1;
        if (cpuValid) begin
          stb.reqLoad = 1'b1;
          nxtState    = sLookup;
        end
      end
      sLookup: begin
        if (hit) begin
          cpuRespValid = 1'b1;
          cpuReady     = 1'b1;
          stb.setPend  = reqWrite;
          if (cpuValid) stb.reqLoad = 1'b1;
          else          nxtState    = sIdle;
        end else if (victimDirty && wbFull) begin
          nxtState = sWaitBuf;
        end else begin
          nxtState = sFill;
        end
      end
      sWaitBuf: begin
        if (!wbFull) nxtState = sFill;
      end
      sFill: begin
        stb.vicCopy = !vicDone && victimDirty;
        if (!wbBusy && wbHit) begin
          stb.installWb = 1'b1;
          nxtState      = sLookup;
        end else if (!wbBusy) begin
          fillReq = 1'b1;
          if (memDone) begin
            stb.installMem = 1'b1;
            nxtState       = sLookup;
          end
        end
      end
      default: nxtState = sIdle;
    endcase
    drainGo       = wbFull && !wbBusy &&
                    ((state == sIdle && !cpuValid) || state == sWaitBuf);
    stb.drainDone = wbBusy && memDone;
    memReq        = wbBusy || fillReq;
    memWrite      = wbBusy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= sIdle;
      vicDone <= 1'b0;
      wbBusy  <= 1'b0;
    end else begin
      state   <= nxtState;
      vicDone <= (state == sFill && nxtState == sFill) ? (vicDone || stb.vicCopy) : 1'b0;
      if (drainGo)            wbBusy <= 1'b1;
      else if (stb.drainDone) wbBusy <= 1'b0;
    end
  end
endmodule

// File: rtl/wbCacheCtl.sv
module wbCacheCtl import wbcPkg::*; #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int SETS   = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cpuValid,
  input  logic                          cpuWrite,
  input  logic [ADDR_W-1:0]             cpuAddr,
  input  logic [DATA_W-1:0]             cpuWdata,
  output logic                          cpuReady,
  output logic                          cpuRespValid,
  output logic [DATA_W-1:0]             cpuRdata,
  output logic                          memReq,
  output logic                          memWrite,
  output logic [ADDR_W-$clog2(WORDS)-1:0] memAddr,
  output logic [DATA_W*WORDS-1:0]       memWdata,
  input  logic                          memDone,
  input  logic [DATA_W*WORDS-1:0]       memRdata
);
  localparam int BLK_W = ADDR_W - $clog2(WORDS);

  dpStrobe_t stb;
  logic hit, victimDirty, wbFull, wbHit, reqWrite;

  wbcControl i_ctl (
    .clk, .rstN, .cpuValid, .hit, .victimDirty, .wbFull, .wbHit, .reqWrite,
    .memDone, .stb, .cpuReady, .cpuRespValid, .memReq, .memWrite
  );

  wbcDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .SETS(SETS)) i_dp (
    .clk, .rstN, .stb, .cpuWrite, .cpuAddr, .cpuWdata, .memWrite, .memRdata,
    .hit, .victimDirty, .wbFull, .wbHit, .reqWrite, .rdData(cpuRdata),
    .memAddr, .memWdata
  );
endmodule

// File: rtl/wbcChecker.sv
module wbcChecker import wbcPkg::*; #(
  parameter int BLK_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             cpuReady,
  input logic             cpuRespValid,
  input logic             memReq,
  input logic             memWrite,
  input logic [BLK_W-1:0] memAddr,
  input logic             memDone,
  input dpStrobe_t        stb
);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memDone) |=> (memReq && $stable(memAddr) && $stable(memWrite)));

  // R2
  resp_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuRespValid |-> cpuReady);

  // R5
  fill_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWrite) |-> (!cpuReady && !cpuRespValid));

  // R7
  drain_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWrite && !$past(memReq && memWrite)) |-> !cpuRespValid);

  // R9
  install_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.installMem, stb.installWb, stb.setPend}));
endmodule

bind wbCacheCtl wbcChecker #(.BLK_W(BLK_W)) i_wbcChecker (
  .clk(clk), .rstN(rstN), .cpuReady(cpuReady), .cpuRespValid(cpuRespValid),
  .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr), .memDone(memDone),
  .stb(stb)
);

// File: tb/test_wbCacheCtl.sv
module test_wbCacheCtl;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 3;

  logic         clk = 1'b0;
  logic         rstN;
  logic         cpuValid, cpuWrite;
  logic [11:0]  cpuAddr;
  logic [31:0]  cpuWdata;
  logic         cpuReady, cpuRespValid;
  logic [31:0]  cpuRdata;
  logic         memReq, memWrite, memDone;
  logic [9:0]   memAddr;
  logic [127:0] memWdata, memRdata;

  logic [31:0] memW   [4096];
  logic [31:0] golden [4096];
  bit          opIsWr [64];
  logic [9:0]  opBlk  [64];
  int opCnt = 0, rdCnt = 0, wrCnt = 0, latCnt = 0;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wbCacheCtl i_wbCacheCtl (
    .clk, .rstN, .cpuValid, .cpuWrite, .cpuAddr, .cpuWdata, .cpuReady,
    .cpuRespValid, .cpuRdata, .memReq, .memWrite, .memAddr, .memWdata,
    .memDone, .memRdata
  );

  // next-level memory model
  initial begin
    memDone  = 1'b0;
    memRdata = '0;
    forever begin
      @(negedge clk);
      if (memDone) begin
        memDone = 1'b0;
      end else if (memReq) begin
        latCnt++;
        if (latCnt == LAT) begin
          latCnt  = 0;
          memDone = 1'b1;
          if (opCnt < 64) begin
            opIsWr[opCnt] = memWrite;
            opBlk[opCnt]  = memAddr;
          end
          opCnt++;
          if (memWrite) begin
            wrCnt++;
            for (int w = 0; w < 4; w++) memW[int'(memAddr)*4 + w] = memWdata[w*32 +: 32];
          end else begin
            rdCnt++;
            for (int w = 0; w < 4; w++) memRdata[w*32 +: 32] = memW[int'(memAddr)*4 + w];
          end
        end
      end else begin
        latCnt = 0;
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(bit we, logic [11:0] a, logic [31:0] d);
    cpuValid = 1'b1; cpuWrite = we; cpuAddr = a; cpuWdata = d;
    while (!cpuReady) @(negedge clk);
    @(negedge clk);
    cpuValid = 1'b0;
  endtask

  task automatic access(bit we, logic [11:0] a, logic [31:0] d,
                        output logic [31:0] rd, output int wait_cycles);
    send(we, a, d);
    wait_cycles = 0;
    while (!cpuRespValid) begin
      @(negedge clk);
      wait_cycles++;
    end
    rd = cpuRdata;
    if (we) golden[a] = d;
  endtask

  task automatic testReset();
    rstN = 1'b0; cpuValid = 1'b0; cpuWrite = 1'b0; cpuAddr = '0; cpuWdata = '0;
    idle(4);
    check("R1 memReq in reset", 32'(memReq), 0);
    check("R1 resp in reset", 32'(cpuRespValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", 32'(cpuReady), 1);
    check("R1 memReq after reset", 32'(memReq), 0);
  endtask

  task automatic testCleanMiss();
    logic [31:0] rd; int w; int r0 = rdCnt, w0 = wrCnt;
    access(0, 12'h101, 0, rd, w);
    check("R5 miss data", rd, golden[12'h101]);
    check("R5 one read", 32'(rdCnt - r0), 1);
    check("R5 no write", 32'(wrCnt - w0), 0);
  endtask

  task automatic testLoadHit();
    logic [31:0] rd; int w; int r0 = rdCnt;
    access(0, 12'h102, 0, rd, w);
    check("R2 hit data", rd, golden[12'h102]);
    check("R2 hit latency", 32'(w), 0);
    check("R2 no traffic", 32'(rdCnt - r0), 0);
  endtask

  task automatic testStoreHit();
    logic [31:0] rd; int w; int r0 = rdCnt, w0 = wrCnt;
    access(1, 12'h103, 32'h1111_AAAA, rd, w);
    check("R3 store hit latency", 32'(w), 0);
    idle(6);
    check("R3 no write-through", 32'(wrCnt - w0), 0);
    check("R3 no read", 32'(rdCnt - r0), 0);
    access(0, 12'h103, 0, rd, w);
    check("R3 reads stored word", rd, 32'h1111_AAAA);
  endtask

  task automatic testBypass();
    logic [31:0] rd; int w;
    access(1, 12'h102, 32'h2222_BBBB, rd, w);
    access(0, 12'h102, 0, rd, w);
    check("R4 bypass data", rd, 32'h2222_BBBB);
    check("R4 bypass latency", 32'(w), 0);
  endtask

  task automatic testDirtyEvict();
    logic [31:0] rd; int w; int s = opCnt, w0 = wrCnt;
    access(0, 12'h120, 0, rd, w);
    check("R6 new block data", rd, golden[12'h120]);
    check("R7 no write before answer", 32'(wrCnt - w0), 0);
    idle(12);
    check("R6 one write", 32'(wrCnt - w0), 1);
    check("R7 first op is read", 32'(opIsWr[s]), 0);
    check("R7 read address", 32'(opBlk[s]), 32'h048);
    check("R7 second op is write", 32'(opIsWr[s+1]), 1);
    check("R6 write address", 32'(opBlk[s+1]), 32'h040);
    check("R6 stored word written", memW[12'h103], 32'h1111_AAAA);
    check("R6 bypassed word written", memW[12'h102], 32'h2222_BBBB);
    check("R6 untouched word written", memW[12'h100], golden[12'h100]);
  endtask

  task automatic testCleanEvict();
    logic [31:0] rd; int w; int r0 = rdCnt, w0 = wrCnt;
    access(0, 12'h140, 0, rd, w);
    idle(12);
    check("R5 clean evict data", rd, golden[12'h140]);
    check("R5 clean evict read", 32'(rdCnt - r0), 1);
    check("R5 clean evict no write", 32'(wrCnt - w0), 0);
  endtask

  task automatic testStoreMiss();
    logic [31:0] rd; int w; int r0 = rdCnt;
    access(1, 12'h205, 32'h3333_CCCC, rd, w);
    check("R8 fill read", 32'(rdCnt - r0), 1);
    access(0, 12'h205, 0, rd, w);
    check("R8 merged word", rd, 32'h3333_CCCC);
    for (int k = 0; k < 4; k++) begin
      if (k == 1) continue;
      access(0, 12'h204 + 12'(k), 0, rd, w);
      check("R8 other word", rd, golden[12'h204 + 12'(k)]);
    end
  endtask

  task automatic testWbForward();
    logic [31:0] rd; int w; int r0, w0;
    idle(12);
    access(1, 12'h009, 32'h4444_DDDD, rd, w);
    r0 = rdCnt; w0 = wrCnt;
    access(0, 12'h028, 0, rd, w);
    check("R9 conflict read", 32'(rdCnt - r0), 1);
    access(0, 12'h009, 0, rd, w);
    check("R9 forwarded data", rd, 32'h4444_DDDD);
    check("R9 no extra read", 32'(rdCnt - r0), 1);
    idle(12);
    check("R9 buffer consumed", 32'(wrCnt - w0), 0);
    access(0, 12'h028, 0, rd, w);
    idle(12);
    check("R9 dirty kept, written", 32'(wrCnt - w0), 1);
    check("R9 written data", memW[12'h009], 32'h4444_DDDD);
  endtask

  task automatic testWaitBuf();
    logic [31:0] rd; int w; int s;
    idle(12);
    s = opCnt;
    access(1, 12'h00C, 32'h5555_EEEE, rd, w);
    access(0, 12'h02C, 0, rd, w);
    access(1, 12'h02C, 32'h6666_FFFF, rd, w);
    access(0, 12'h04C, 0, rd, w);
    check("R10 third block data", rd, golden[12'h04C]);
    idle(12);
    check("R10 op count", 32'(opCnt - s), 5);
    check("R10 op0 read", {opIsWr[s],   22'd0, opBlk[s]},   {1'b0, 22'd0, 10'h003});
    check("R10 op1 read", {opIsWr[s+1], 22'd0, opBlk[s+1]}, {1'b0, 22'd0, 10'h00B});
    check("R10 op2 drain", {opIsWr[s+2], 22'd0, opBlk[s+2]}, {1'b1, 22'd0, 10'h003});
    check("R10 op3 read", {opIsWr[s+3], 22'd0, opBlk[s+3]}, {1'b0, 22'd0, 10'h013});
    check("R10 op4 victim", {opIsWr[s+4], 22'd0, opBlk[s+4]}, {1'b1, 22'd0, 10'h00B});
    check("R10 first victim data", memW[12'h00C], 32'h5555_EEEE);
    check("R10 second victim data", memW[12'h02C], 32'h6666_FFFF);
  endtask

  initial begin
    for (int a = 0; a < 4096; a++) begin
      memW[a]   = 32'hC0DE_0000 | 32'(a);
      golden[a] = 32'hC0DE_0000 | 32'(a);
    end
    @(negedge clk);
    testReset();      // R1, R12 address layout used throughout
    testCleanMiss();
    testLoadHit();
    testStoreHit();
    testBypass();
    testDirtyEvict();
    testCleanEvict();
    testStoreMiss();
    testWbForward();
    testWaitBuf();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule